// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block controls 32 general-purpose I/O lines. A host reaches it through a 32-bit register port with a single request strobe. Each line owns a 4-bit field, and eight fields are packed into each of four 32-bit registers. The two low bits of a field set how the line's pad is driven. Bit 2 reads back the pad's input level after a two-flop synchronizer. Bit 3 is reserved.

All fields of a register are written together. A host that wants to change one line therefore reads the register, edits that line's two control bits and writes the word back. The controls of the other lines come back unchanged, so the other lines are not disturbed. The sampled input bits and the reserved bits that the host writes back are ignored.

The request side has no back-pressure. The block accepts every strobed request in the cycle it is presented, so there is no ready signal. A read answers with a one-cycle response pulse on the following cycle, and the host must take the data in that cycle. A write produces no response.

Top module: `gpio_ctrl_bank`

## Requirements
- R1: Line N is held in the register whose index is N/8. The index is taken from address bits [3:2]. Within that register the line's field starts at bit 4*(N mod 8).
- R2: An accepted write (req_valid=1, req_write=1) loads field bits [1:0] of all eight lines in the addressed register from the matching bits of req_wdata. Field bits 2 and 3 of req_wdata are ignored.
- R3: pad_out[N] always equals bit 0 of line N's field.
- R4: pad_oe[N] is the inverse of bit 1 of line N's field. A value of 0 in bit 1 drives the pad, and a value of 1 tri-states it.
- R5: In read data, bit 2 of each field holds the line's pad input after two clock edges of synchronization, and bit 3 of each field reads 0.
- R6: A write leaves the control bits of every line in the other registers unchanged. Reading a register and writing the same word back leaves every line's control unchanged.
- R7: While rst_n is low, every field's control bits are 2'b10. This gives pad_oe all zero and pad_out all zero. rsp_valid is 0 and the synchronizer holds 0.
- R8: An accepted read raises rsp_valid for exactly the next cycle, with rsp_rdata holding the addressed register. A write or an idle cycle gives rsp_valid=0 in the next cycle. Address bits [1:0] are ignored.
- R9: In a cycle with req_valid=0, no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, accepted in the cycle it is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address; bits [3:2] select the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 = drive |

## Verification
Directed single-bit writes and reads tell apart the line-to-register and field-offset mapping (R1). They also distinguish the level bit from the enable bit, with the enable read as active low. A lone pad input edge, followed by a read-modify-write, shows the two-cycle input latency and that the input and reserved bits written back are dropped. A long random mix of reads, writes, idle cycles, back-to-back requests, nonzero low address bits and changing pad inputs is compared every cycle against a behavioural model. That run exposes cross-register corruption, stray responses and any change made in an idle cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int FIELD_W     = 4;
  localparam int CTRL_W      = 2;
  localparam int LVL_BIT     = 0;
  localparam int OE_N_BIT    = 1;
  localparam int IN_BIT      = 2;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 2'b10;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int DATA_W        = 32,
  parameter int REG_IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [REG_IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_LINES*CTRL_W-1:0] ctrl_flat,
  output logic [NUM_LINES-1:0]        pad_out,
  output logic [NUM_LINES-1:0]        pad_oe
);
  logic [DATA_W-1:0] unused_wdata;
  assign unused_wdata = wr_data;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int REG_SEL = n / LINES_PER_REG;
    localparam int LSB     = (n % LINES_PER_REG) * FIELD_W;
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q <= CTRL_RESET;
      else if (wr_en && (wr_idx == REG_IDX_W'(REG_SEL)))
        ctrl_q <= wr_data[LSB +: CTRL_W];
    end

    assign ctrl_flat[n*CTRL_W +: CTRL_W] = ctrl_q;
    assign pad_out[n] = ctrl_q[LVL_BIT];
    assign pad_oe[n]  = ~ctrl_q[OE_N_BIT];
  end
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int DATA_W        = 32,
  parameter int REG_IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [REG_IDX_W-1:0]        rd_idx,
  input  logic [NUM_LINES*CTRL_W-1:0] ctrl_flat,
  input  logic [NUM_LINES-1:0]        sync_in,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata
);
  localparam int NUM_REGS = NUM_LINES / LINES_PER_REG;

  logic [NUM_REGS-1:0][DATA_W-1:0] reg_word;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar j = 0; j < LINES_PER_REG; j++) begin : g_lane
      localparam int LN = r * LINES_PER_REG + j;
      assign reg_word[r][j*FIELD_W +: FIELD_W] =
        {1'b0, sync_in[LN], ctrl_flat[LN*CTRL_W +: CTRL_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en)
        rsp_rdata <= reg_word[rd_idx];
    end
  end
endmodule

// File: rtl/gpio_ctrl_bank.sv
module gpio_ctrl_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  localparam int NUM_REGS  = NUM_LINES / LINES_PER_REG;
  localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                        wr_en, rd_en;
  logic [REG_IDX_W-1:0]        sel_idx;
  logic [NUM_LINES*CTRL_W-1:0] ctrl_flat;
  logic [NUM_LINES-1:0]        pad_sync;
  logic [ADDR_W-1:0]           unused_addr;

  assign unused_addr = req_addr;
  assign sel_idx     = req_addr[REG_IDX_W+1:2];
  assign wr_en       = req_valid &  req_write;
  assign rd_en       = req_valid & ~req_write;

  gpio_in_sync #(.W(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_out_ctrl #(
    .NUM_LINES(NUM_LINES), .LINES_PER_REG(LINES_PER_REG),
    .DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (sel_idx),
    .wr_data   (req_wdata),
    .ctrl_flat (ctrl_flat),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  gpio_read_port #(
    .NUM_LINES(NUM_LINES), .LINES_PER_REG(LINES_PER_REG),
    .DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_idx    (sel_idx),
    .ctrl_flat (ctrl_flat),
    .sync_in   (pad_sync),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/gpio_ctrl_bank_chk.sv
module gpio_ctrl_bank_chk #(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [DATA_W-1:0]    req_wdata,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe
);
  function automatic logic [DATA_W-1:0] rsvd_mask();
    logic [DATA_W-1:0] m = '0;
    for (int j = 0; j < LINES_PER_REG; j++) m[j*4+3] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] RSVD = rsvd_mask();

  // R7
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (pad_oe == '0 && pad_out == '0 && !rsp_valid));

  // R8
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R8
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(pad_out) && $stable(pad_oe)));

  // R3
  line0_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[3:2] == 2'd0) |=> (pad_out[0] == $past(req_wdata[0])));

  // R4
  line0_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[3:2] == 2'd0) |=> (pad_oe[0] == !$past(req_wdata[1])));

  // R6
  other_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[3:2] != 2'd0) |=> ($stable(pad_out[7:0]) && $stable(pad_oe[7:0])));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & RSVD) == '0));
endmodule

bind gpio_ctrl_bank gpio_ctrl_bank_chk #(
  .NUM_LINES(NUM_LINES), .LINES_PER_REG(LINES_PER_REG),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_ctrl_bank.sv
module tb_gpio_ctrl_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, pad_in = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata, pad_out, pad_oe;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  gpio_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model
  logic [1:0]  m_ctrl [32];
  logic [31:0] m_hist [$];
  logic        m_rsp_valid;
  logic [31:0] m_rsp_rdata;

  function automatic logic [31:0] model_word(int idx);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) begin
      int ln = idx * 8 + j;
      w[j*4 +: 4] = {1'b0, m_hist[0][ln], m_ctrl[ln]};
    end
    return w;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_ctrl[i] = 2'b10;
    m_hist = {32'h0, 32'h0};
    m_rsp_valid = 0;
    m_rsp_rdata = '0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      m_rsp_valid = 0;
      if (req_valid && !req_write) begin
        m_rsp_valid = 1;
        m_rsp_rdata = model_word(int'(req_addr[3:2]));
      end
      if (req_valid && req_write)
        for (int j = 0; j < 8; j++) m_ctrl[int'(req_addr[3:2])*8 + j] = req_wdata[j*4 +: 2];
      m_hist.push_back(pad_in);
      void'(m_hist.pop_front());
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [31:0] eo, ee;
      for (int i = 0; i < 32; i++) begin
        eo[i] = m_ctrl[i][0];
        ee[i] = ~m_ctrl[i][1];
      end
      check("R3 pad_out", pad_out, eo);
      check("R4 pad_oe", pad_oe, ee);
      check("R8 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rsp_valid});
      if (m_rsp_valid) check("R1/R5 rsp_rdata", rsp_rdata, m_rsp_rdata);
    end
  end

  task automatic wr(int idx, logic [31:0] d, logic [1:0] lo = 2'b00);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = {idx[1:0], lo}; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(int idx, logic [31:0] exp, string tag, logic [1:0] lo = 2'b00);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = {idx[1:0], lo};
    @(negedge clk);
    req_valid = 0;
    check(tag, rsp_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rmw;
    repeat (2) @(negedge clk);
    // R7 reset state
    check("R7 pad_oe in reset", pad_oe, 32'h0);
    check("R7 pad_out in reset", pad_out, 32'h0);
    check("R7 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1;
    for (int r = 0; r < 4; r++) rd(r, 32'h2222_2222, "R7 reset fields");
    // R2 R3 R4: line 8 driven high, rest of register 1 driven low; bits 2/3 ignored
    wr(1, 32'hCCCC_CCCD);
    check("R3 line8 level", {31'b0, pad_out[8]}, 32'h1);
    check("R4 line8 enable", {31'b0, pad_oe[8]}, 32'h1);
    rd(1, 32'h0000_0001, "R2 reg1 readback");
    // R1 R5: pad input on line 13 at field 5, bit 22, after sync
    pad_in = 32'h0000_2000;
    repeat (3) @(negedge clk);
    rd(1, 32'h0040_0001, "R5 line13 input", 2'b11);
    // R6 read-modify-write: set line 9 field to 3
    rmw = 32'h0040_0001 | 32'h0000_0030 | 32'h8888_8888;
    wr(1, rmw);
    rd(1, 32'h0040_0031, "R6 rmw target");
    rd(0, 32'h2222_2222, "R6 other reg untouched");
    // R9 idle cycles
    repeat (4) @(negedge clk);
    rd(1, 32'h0040_0031, "R9 idle hold");
    // R8 back-to-back reads, random mix compared by the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 3) != 0);
      req_write = $urandom_range(0, 1) == 1;
      req_addr  = 4'($urandom);
      req_wdata = $urandom;
      if ($urandom_range(0, 7) == 0) pad_in = $urandom;
    end
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule